// File: doc/BRIEF.md
# Alarm-Armed Periodic Pulse Generator

This block drives up to three pulse outputs that stay phase-locked to a 64-bit nanosecond time value supplied by a precision time counter. A channel does nothing until alarm 1 matches the time value. From then on it produces one pulse per programmed interval, so a once-per-second output lands on whole seconds. Software programs each channel through a small word-addressed register port. Each channel has a 32-bit interval, a disable bit, an output gate bit, a start-on-alarm bit and a 5-bit pulse width counted in clock cycles.

Around a time step or a change of tick period, software disables the channel, loads the all-ones interval and moves the time counter. It then writes a new alarm and enables the channel again. The channel forgets its old phase and waits for the new alarm match. Pulse starts and alarm matches are recorded in a write-one-to-clear event register, gated by a mask register. The interrupt output is raised while any masked event is pending.

Top module: `aligned_pulse_gen`

## Requirements
- R1: After reset the outputs and the interrupt are low, the event and mask registers read 0, both alarm words and all three interval words read all ones, and the control word reads 0x00808080 (every channel disabled).
- R2: Registers sit at word addresses 0 event, 1 mask, 2/3 alarm 1 low/high, 4/5 alarm 2 low/high, 6/7/8 interval of channel 0/1/2, and 9 control. Channel i owns control bits 8i+7..8i: bit 7 disable, bit 6 output gate, bit 5 start-on-alarm, bits 4:0 pulse width. Mask and interval read back what was written.
- R3: With start-on-alarm set, the first pulse begins at the clock edge where the time value first reaches or passes alarm 1.
- R4: With start-on-alarm clear, the alarm 1 match only sets the phase, and the first pulse begins when the time reaches the alarm value plus the interval plus the tick increment.
- R5: Each further pulse begins when the time reaches the previous pulse start plus the interval plus the tick increment.
- R6: A pulse stays high for exactly the number of clock cycles in the width field.
- R7: With the gate bit clear, the output stays low, but the channel still keeps time and still raises its event.
- R8: A set disable bit drives the output low from the next cycle on and discards the channel's phase. A re-enabled channel gives no pulse until the next alarm 1 match.
- R9: An alarm fires once: on a match its register returns to all ones, which never matches, and event bit 16 (alarm 1) or 17 (alarm 2) is raised.
- R10: Channel i reports pulse starts at event bit 7-i. An event bit is set only while its mask bit is set, and the interrupt is the OR of the masked pending events.
- R11: Writing ones to the event register clears those bits. A new event arriving in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the unit of pulse width |
| rst_n | input | 1 | Active-low synchronous reset |
| time_ns | input | 64 | Current time value from the time counter, in ns |
| tick_ns | input | 16 | Time counter increment per tick, in ns |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pulse_out | output | 3 | Pulse output per channel |
| irq | output | 1 | Masked event pending |

## Verification
A channel can start a pulse, and so set its event bit, in the same cycle that software writes a one to clear that bit. The bench knows the exact time of each pulse start. It waits until the time value is one tick short of a known start, then holds a clear write so that the write lands on the same edge as the new event. It expects the bit to read back as set, and it expects a plain clear issued later, between pulses, to leave the bit at zero.

// File: rtl/apg_pkg.sv
package apg_pkg;
   // register word addresses
   localparam int ADR_EVT      = 0;
   localparam int ADR_MASK     = 1;
   localparam int ADR_ALM_BASE = 2;   // two words per alarm: low, high
   localparam int ADR_IVL_BASE = 6;   // one word per channel
   localparam int ADR_CTRL     = 9;
   localparam int ADR_SPAN     = 10;

   // event bit positions
   localparam int EVT_CH_TOP    = 7;  // channel i at EVT_CH_TOP - i
   localparam int EVT_ALARM_LOW = 16; // alarm k at EVT_ALARM_LOW + k

   localparam int NUM_ALM  = 2;
   localparam int CTRL_BITS = 8;

   typedef struct packed {
      logic       dis;
      logic       gate;
      logic       from_alarm;
      logic [4:0] width;
   } ch_ctrl_t;
endpackage

// File: rtl/apg_alarm.sv
module apg_alarm #(
   parameter int TIME_W = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_ns,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [TIME_W-1:0] cmp_q,
   output logic              hit
);
   localparam logic [TIME_W-1:0] IDLE_VAL = '1;

   assign hit = (cmp_q != IDLE_VAL) && (time_ns >= cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q <= IDLE_VAL;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) cmp_q[DATA_W-1:0]      <= wdata;
         if (wr_hi) cmp_q[TIME_W-1:DATA_W] <= wdata;
      end else if (hit) begin
         cmp_q <= IDLE_VAL;
      end
   end
endmodule

// File: rtl/apg_channel.sv
module apg_channel
   import apg_pkg::*;
#(
   parameter int TIME_W = 64,
   parameter int IVL_W  = 32,
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_ns,
   input  logic [TICK_W-1:0] tick_ns,
   input  logic [IVL_W-1:0]  interval,
   input  ch_ctrl_t          ctrl,
   input  logic              alarm_hit,
   input  logic [TIME_W-1:0] alarm_val,
   output logic              pulse,
   output logic              fire
);
   typedef enum logic [1:0] {ST_OFF, ST_WAIT, ST_RUN} ch_state_t;

   ch_state_t         state_q;
   logic [TIME_W-1:0] next_q;
   logic [4:0]        cnt_q;
   logic              pulse_q;
   logic [TIME_W-1:0] step;

   assign step  = TIME_W'(interval) + TIME_W'(tick_ns);
   assign pulse = pulse_q;

   always_comb begin
      fire = 1'b0;
      if (!ctrl.dis) begin
         case (state_q)
            ST_WAIT: fire = alarm_hit && ctrl.from_alarm;
            ST_RUN:  fire = (time_ns >= next_q);
            default: fire = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || ctrl.dis) begin
         state_q <= ST_OFF;
         next_q  <= '0;
         cnt_q   <= '0;
         pulse_q <= 1'b0;
      end else begin
         case (state_q)
            ST_OFF:  state_q <= ST_WAIT;
            ST_WAIT: if (alarm_hit) begin
                        state_q <= ST_RUN;
                        next_q  <= alarm_val + step;
                     end
            ST_RUN:  if (fire) next_q <= next_q + step;
            default: state_q <= ST_OFF;
         endcase
         if (fire && ctrl.gate && (ctrl.width != 5'd0)) begin
            pulse_q <= 1'b1;
            cnt_q   <= ctrl.width - 5'd1;
         end else if (pulse_q) begin
            if (cnt_q == 5'd0) pulse_q <= 1'b0;
            else               cnt_q   <= cnt_q - 5'd1;
         end
      end
   end
endmodule

// File: rtl/apg_regs.sv
module apg_regs
   import apg_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int TIME_W = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [DATA_W-1:0]              wdata,
   input  logic [NUM_CH-1:0]              ch_fire,
   input  logic [NUM_ALM-1:0]             alm_hit,
   input  logic [NUM_ALM-1:0][TIME_W-1:0] alm_val,
   output logic [NUM_ALM-1:0]             alm_wr_lo,
   output logic [NUM_ALM-1:0]             alm_wr_hi,
   output logic [NUM_CH-1:0][DATA_W-1:0]  ivl_q,
   output ch_ctrl_t [NUM_CH-1:0]          ctrl_q,
   output logic [DATA_W-1:0]              evt_q,
   output logic [DATA_W-1:0]              mask_q,
   output logic [DATA_W-1:0]              rdata,
   output logic                           irq
);
   logic [DATA_W-1:0] evt_set, evt_clr;
   int unsigned       a;

   assign a = unsigned'(int'(addr));

   always_comb begin
      evt_set = '0;
      for (int i = 0; i < NUM_CH; i++) evt_set[EVT_CH_TOP-i] = ch_fire[i];
      for (int k = 0; k < NUM_ALM; k++) evt_set[EVT_ALARM_LOW+k] = alm_hit[k];
      evt_clr = (we && a == ADR_EVT) ? wdata : '0;
   end

   always_comb begin
      for (int k = 0; k < NUM_ALM; k++) begin
         alm_wr_lo[k] = we && (a == unsigned'(ADR_ALM_BASE + 2*k));
         alm_wr_hi[k] = we && (a == unsigned'(ADR_ALM_BASE + 2*k + 1));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            ivl_q[i]  <= '1;
            ctrl_q[i] <= '{dis: 1'b1, gate: 1'b0, from_alarm: 1'b0, width: 5'd0};
         end
      end else begin
         evt_q <= (evt_q & ~evt_clr) | (evt_set & mask_q);
         if (we && a == ADR_MASK) mask_q <= wdata;
         for (int i = 0; i < NUM_CH; i++) begin
            if (we && a == unsigned'(ADR_IVL_BASE + i)) ivl_q[i] <= wdata;
            if (we && a == ADR_CTRL) ctrl_q[i] <= wdata[CTRL_BITS*i +: CTRL_BITS];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (a == ADR_EVT)  rdata = evt_q;
      if (a == ADR_MASK) rdata = mask_q;
      for (int k = 0; k < NUM_ALM; k++) begin
         if (a == unsigned'(ADR_ALM_BASE + 2*k))     rdata = alm_val[k][DATA_W-1:0];
         if (a == unsigned'(ADR_ALM_BASE + 2*k + 1)) rdata = alm_val[k][TIME_W-1:DATA_W];
      end
      for (int i = 0; i < NUM_CH; i++) begin
         if (a == unsigned'(ADR_IVL_BASE + i)) rdata = ivl_q[i];
         if (a == ADR_CTRL) rdata[CTRL_BITS*i +: CTRL_BITS] = ctrl_q[i];
      end
   end

   assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/aligned_pulse_gen.sv
module aligned_pulse_gen
   import apg_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int TIME_W = 64,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4,
   parameter int TICK_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] time_ns,
   input  logic [TICK_W-1:0] tick_ns,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [NUM_CH-1:0] pulse_out,
   output logic              irq
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
      $error("NUM_CH must be 1 to 3");
   end
   if (TIME_W != 2*DATA_W) begin : g_bad_tw
      $error("TIME_W must be twice DATA_W");
   end
   if ((1 << ADDR_W) < ADR_SPAN) begin : g_bad_aw
      $error("ADDR_W too narrow for the register map");
   end
   if (TICK_W > DATA_W) begin : g_bad_tick
      $error("TICK_W must not exceed DATA_W");
   end

   logic [NUM_ALM-1:0]             alm_hit, alm_wr_lo, alm_wr_hi;
   logic [NUM_ALM-1:0][TIME_W-1:0] alm_val;
   logic [NUM_CH-1:0][DATA_W-1:0]  ivl_q;
   ch_ctrl_t [NUM_CH-1:0]          ctrl_q;
   logic [NUM_CH-1:0]              ch_fire, ch_dis, ch_gate;
   logic [DATA_W-1:0]              evt_q, mask_q;

   apg_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIME_W(TIME_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .ch_fire(ch_fire), .alm_hit(alm_hit), .alm_val(alm_val),
      .alm_wr_lo(alm_wr_lo), .alm_wr_hi(alm_wr_hi), .ivl_q(ivl_q), .ctrl_q(ctrl_q),
      .evt_q(evt_q), .mask_q(mask_q), .rdata(reg_rdata), .irq(irq)
   );

   for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
      apg_alarm #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_alm (
         .clk(clk), .rst_n(rst_n), .time_ns(time_ns),
         .wr_lo(alm_wr_lo[k]), .wr_hi(alm_wr_hi[k]), .wdata(reg_wdata),
         .cmp_q(alm_val[k]), .hit(alm_hit[k])
      );
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign ch_dis[i]  = ctrl_q[i].dis;
      assign ch_gate[i] = ctrl_q[i].gate;
      apg_channel #(.TIME_W(TIME_W), .IVL_W(DATA_W), .TICK_W(TICK_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .tick_ns(tick_ns),
         .interval(ivl_q[i]), .ctrl(ctrl_q[i]),
         .alarm_hit(alm_hit[0]), .alarm_val(alm_val[0]),
         .pulse(pulse_out[i]), .fire(ch_fire[i])
      );
   end
endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
   parameter int NUM_CH = 3,
   parameter int TIME_W = 64,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] pulse_out,
   input logic [NUM_CH-1:0] ch_dis,
   input logic [NUM_CH-1:0] ch_gate,
   input logic [DATA_W-1:0] evt_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              alm0_hit,
   input logic              alm0_wr,
   input logic [TIME_W-1:0] alm0_val
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assert_disable_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
         ch_dis[i] |=> !pulse_out[i]);
      assert_gate_needed_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pulse_out[i]) |-> $past(ch_gate[i]));
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_evt
      assert_event_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(evt_q[b]) |-> $past(mask_q[b]));
   end

   assert_alarm_oneshot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (alm0_hit && !alm0_wr) |=> (alm0_val == '1));
endmodule

bind aligned_pulse_gen apg_checker #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .DATA_W(DATA_W)) u_apg_chk (
   .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out), .ch_dis(ch_dis), .ch_gate(ch_gate),
   .evt_q(evt_q), .mask_q(mask_q), .alm0_hit(alm_hit[0]),
   .alm0_wr(alm_wr_lo[0] | alm_wr_hi[0]), .alm0_val(alm_val[0])
);

// File: tb/test_aligned_pulse_gen.sv
`timescale 1ns/1ps
module test_aligned_pulse_gen;
   localparam int TICK = 8;
   localparam int IVL  = 96;
   localparam int PER  = IVL + TICK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] time_ns = '0;
   logic [63:0] jump_ns = '0;
   logic [15:0] tick_ns = 16'(TICK);
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   wire  [31:0] reg_rdata;
   wire  [2:0]  pulse_out;
   wire         irq;

   int checks = 0;
   int fails  = 0;

   aligned_pulse_gen i_aligned_pulse_gen (
      .clk(clk), .rst_n(rst_n), .time_ns(time_ns), .tick_ns(tick_ns),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pulse_out(pulse_out), .irq(irq)
   );

   initial forever #2.5 clk = ~clk;

   // time counter model: advances one tick per clock, at the falling edge
   initial forever begin
      @(negedge clk);
      if (rst_n) time_ns <= time_ns + 64'(TICK) + jump_ns;
   end

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(posedge clk); #1;
      reg_addr = 4'(a);
      #0.5 d = reg_rdata;
   endtask

   task automatic set_alarm(input int k, input logic [63:0] v);
      wr(2 + 2*k, v[31:0]);
      wr(3 + 2*k, v[63:32]);
   endtask

   function automatic logic [63:0] next_alarm();
      return ((time_ns >> 3) + 64'd24) << 3;
   endfunction

   // sample after each edge; record time of the first two rises and the first width
   task automatic watch(input int ch, input int limit, output logic [63:0] r0,
                        output logic [63:0] r1, output int w0);
      int  nr = 0;
      logic prev = pulse_out[ch];
      r0 = '1; r1 = '1; w0 = 0;
      for (int c = 0; c < limit && nr < 2; c++) begin
         @(posedge clk); #1;
         if (pulse_out[ch] && !prev) begin
            if (nr == 0) r0 = time_ns; else r1 = time_ns;
            nr++;
         end
         if (pulse_out[ch] && nr == 1) w0++;
         prev = pulse_out[ch];
      end
   endtask

   task automatic count_high(input int ch, input int n, output int highs);
      highs = 0;
      for (int c = 0; c < n; c++) begin
         @(posedge clk); #1;
         if (pulse_out[ch]) highs++;
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk(pulse_out == 3'b0 && irq == 1'b0, "R1 outputs low", {pulse_out, irq}, 0);
      rd(0, d); chk(d == 0, "R1 event", d, 0);
      rd(1, d); chk(d == 0, "R1 mask", d, 0);
      rd(2, d); chk(d == 32'hffff_ffff, "R1 alarm1 low", d, 32'hffff_ffff);
      rd(5, d); chk(d == 32'hffff_ffff, "R1 alarm2 high", d, 32'hffff_ffff);
      rd(8, d); chk(d == 32'hffff_ffff, "R1 interval2", d, 32'hffff_ffff);
      rd(9, d); chk(d == 32'h0080_8080, "R1 control", d, 32'h0080_8080);
      wr(1, 32'h0000_abcd); rd(1, d); chk(d == 32'h0000_abcd, "R2 mask readback", d, 32'habcd);
      wr(7, 32'h1234_5678); rd(7, d); chk(d == 32'h1234_5678, "R2 interval1 readback", d, 32'h12345678);
      wr(1, 0);
   endtask

   task automatic t_alarm_start();
      logic [63:0] a, r0, r1; int w; logic [31:0] d;
      wr(1, (32'h1 << 7) | (32'h1 << 16) | (32'h1 << 17));
      wr(6, IVL);
      wr(9, 32'h0080_8063);              // ch0: gate, start-on-alarm, width 3
      a = next_alarm();
      set_alarm(0, a);
      set_alarm(1, a);
      watch(0, 120, r0, r1, w);
      chk(r0 == a, "R3 first pulse at alarm", r0, a);
      chk(r1 == a + PER, "R5 second pulse", r1, a + PER);
      chk(w == 3, "R6 width 3", 64'(w), 3);
      rd(0, d); chk((d & 32'h0003_0080) == 32'h0003_0080, "R9 R10 events 7,16,17", d, 32'h30080);
      chk(irq == 1'b1, "R10 irq raised", irq, 1);
      rd(2, d); chk(d == 32'hffff_ffff, "R9 alarm1 one-shot", d, 32'hffff_ffff);
      rd(4, d); chk(d == 32'hffff_ffff, "R9 alarm2 one-shot", d, 32'hffff_ffff);
   endtask

   task automatic t_disable_rearm();
      logic [63:0] a, r0, r1; int w, h; logic [31:0] d;
      wr(9, 32'h0080_8080);
      wr(6, 32'hffff_ffff);
      wr(0, 32'hffff_ffff);
      rd(0, d); chk(d == 0, "R11 events cleared", d, 0);
      chk(irq == 1'b0, "R10 irq clear", irq, 0);
      count_high(0, 30, h); chk(h == 0, "R8 disabled output low", 64'(h), 0);
      rd(0, d); chk(d == 0, "R8 no events while disabled", d, 0);
      @(posedge clk); #1 jump_ns = 64'd4000;
      @(posedge clk); #1 jump_ns = 64'd0;
      wr(6, IVL);
      wr(9, 32'h0080_8063);
      count_high(0, 30, h); chk(h == 0, "R8 waits for alarm", 64'(h), 0);
      a = next_alarm();
      set_alarm(0, a);
      watch(0, 120, r0, r1, w);
      chk(r0 == a, "R8 realigned to new alarm", r0, a);
      chk(r1 == a + PER, "R5 after rearm", r1, a + PER);
      wr(9, 32'h0080_8080);
      wr(1, 0);
      wr(0, 32'hffff_ffff);
   endtask

   task automatic t_phase_only();
      logic [63:0] a, r0, r1; int w; logic [31:0] d;
      wr(7, IVL);
      wr(9, 32'h0080_4280);              // ch1: gate, width 2, no start-on-alarm
      a = next_alarm();
      set_alarm(0, a);
      watch(1, 120, r0, r1, w);
      chk(r0 == a + PER, "R4 first pulse one period after alarm", r0, a + PER);
      chk(r1 == a + 2*PER, "R5 ch1 second pulse", r1, a + 2*PER);
      chk(w == 2, "R6 width 2", 64'(w), 2);
      rd(0, d); chk(d == 0, "R10 masked-off events stay clear", d, 0);
      chk(irq == 1'b0, "R10 irq low with mask clear", irq, 0);
      wr(9, 32'h0080_8080);
   endtask

   task automatic t_gate_and_clear();
      logic [63:0] a, tn; int h; logic [31:0] d;
      wr(1, 32'h1 << 5);
      wr(8, IVL);
      wr(9, 32'h0024_8080);              // ch2: start-on-alarm, width 4, gate off
      a = next_alarm();
      set_alarm(0, a);
      h = 0;
      while (time_ns < a + 2*PER + TICK) begin
         @(posedge clk); #1;
         if (pulse_out[2]) h++;
      end
      chk(h == 0, "R7 gated output stays low", 64'(h), 0);
      rd(0, d); chk(d[5] == 1'b1, "R7 R10 event bit 5 raised", d, 32'h20);
      chk(irq == 1'b1, "R10 irq from ch2", irq, 1);
      // clear write landing on the same edge as a new pulse start
      tn = a;
      while (tn < time_ns + 4*TICK) tn += PER;
      do begin @(posedge clk); #1; end while (time_ns != tn - TICK);
      reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1 << 5;
      @(posedge clk); #1;
      reg_we = 1'b0;
      rd(0, d); chk(d[5] == 1'b1, "R11 set wins over clear", d, 32'h20);
      wr(0, 32'h1 << 5);
      rd(0, d); chk(d[5] == 1'b0, "R11 plain clear", d, 0);
      wr(9, 32'h0080_8080);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_alarm_start();
      t_disable_rearm();
      t_phase_only();
      t_gate_and_clear();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule